// File: doc/BRIEF.md
# Interrupt status aggregation unit

This block gathers sixteen interrupt sources into a single 32-bit status word that a processor fetches over a simple register bus. The low sixteen bits carry the sources and the upper sixteen always read as zero. The bus has a write strobe, a read strobe and an address. Write data is never needed, because every clearing write acts on its address alone.

The bits do not share one clearing mechanism. Eight bits follow asynchronous pins, each through a two-flop synchroniser. Some of these pins are active-low and some are active-high. Two bits follow level outputs of a serial port. Two timer bits are armed by an underflow pulse and latch on the next falling edge of that timer's clock. Three bits latch on an event pulse: the calendar match, the periodic tick and the modem line change. Each of these five latched bits is cleared by a write of any value to its own end-of-interrupt address. The converter end-of-transfer bit latches when a transfer completes and is cleared as a side effect of a read of the converter data address.

If a set event and a clear for the same bit arrive in the same cycle, the set wins. This ensures no event is lost. A read of the status address returns the word one cycle later, marked by a valid strobe.

Top module: `irq_status_agg`

## Requirements
- R1: When reset is released, `irq_status` is 0, `rd_valid` is 0 and `rd_data` is 0, provided every pin is held at its passive level.
- R2: A read strobe at the status address (default 0x10) gives `rd_valid` high for one cycle, one clock later. In that cycle `rd_data` holds the status as it stood at the read, with bits 31..16 zero.
- R3: Bits 1 (battery low), 2 (watchdog), 3 (media change), 4 (codec) and 7 (external 3) are set while their pins are high. Each change appears in `irq_status` three clocks after the pin changes.
- R4: Bits 0 (fast interrupt), 5 (external 1) and 6 (external 2) are set while their pins are low. They clear when the pins return high, with the same three-clock latency.
- R5: Bits 8 and 9 are timer 1 and timer 2. Each bit sets on the first falling edge of that timer's clock that follows an underflow pulse, and appears three clocks after the edge. A falling edge with no underflow pending does not set the bit.
- R6: A write to the timer 1 EOI address (0x20) clears bit 8 only. A write to the timer 2 EOI address (0x24) clears bit 9 only.
- R7: Bits 10 (calendar match), 11 (tick) and 14 (modem change) latch one clock after their event pulse. They are cleared only by a write to their own EOI address: 0x28, 0x2C and 0x30 respectively.
- R8: Bit 15 latches one clock after `ssi_done`. A read strobe at the converter data address (0x38) clears it, and a write to that address leaves it set.
- R9: Bits 12 and 13 follow `uart_tx_lvl` and `uart_rx_lvl` with one clock of latency.
- R10: A set event and a clear for the same latched bit in the same cycle leave the bit set.
- R11: A write to the status address changes no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | ADDR_W | Register bus address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| fiq_n | input | 1 | Fast interrupt pin, active low |
| bat_low | input | 1 | Battery-low pin, active high |
| wdog_exp | input | 1 | Watchdog-expired pin, active high |
| media_chg | input | 1 | Media-changed pin, active high |
| codec_irq | input | 1 | Codec pin, active high |
| ext1_n | input | 1 | External interrupt 1, active low |
| ext2_n | input | 1 | External interrupt 2, active low |
| ext3 | input | 1 | External interrupt 3, active high |
| tmr_clk | input | 2 | Timer clocks, asynchronous |
| tmr_uflow | input | 2 | Timer underflow pulses |
| rtc_match | input | 1 | Calendar match event pulse |
| tick_evt | input | 1 | Periodic tick event pulse |
| modem_evt | input | 1 | Modem line change event pulse |
| ssi_done | input | 1 | Converter transfer complete pulse |
| uart_tx_lvl | input | 1 | Serial transmit request level |
| uart_rx_lvl | input | 1 | Serial receive request level |
| irq_status | output | 16 | Registered status bits |
| rd_data | output | 32 | Read data |
| rd_valid | output | 1 | Read data valid |

## Verification
Each latched bit is its own sticky flop, so a fault in the clear decode or the set-priority shows on `irq_status` on the clock right after the offending write, read or event. A slip in the pin path shows as a wrong polarity, or as a latency other than three clocks. The timer arming state is hidden, and a fault there appears only when the timer clock falls, three clocks after that edge. A fault in the readback shows in the valid strobe or word one clock after the read.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;
  localparam int NSRC   = 16;
  localparam int DATA_W = 32;
  localparam int NPIN   = 8;
  localparam int NTMR   = 2;

  localparam int B_FIQ  = 0;
  localparam int B_TMR1 = 8;
  localparam int B_TMR2 = 9;
  localparam int B_RTC  = 10;
  localparam int B_TICK = 11;
  localparam int B_UTX  = 12;
  localparam int B_URX  = 13;
  localparam int B_MDM  = 14;
  localparam int B_SEOT = 15;

  typedef logic [NSRC-1:0] src_vec_t;

  // bits held by a sticky flop; all others follow a level
  localparam src_vec_t LATCH_MASK = 16'b1100_1111_0000_0000;
  // pin bits 0..7 that are asserted low
  localparam logic [NPIN-1:0] PIN_ACT_LOW = 8'b0110_0001;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/irq_tmr_arm.sv
module irq_tmr_arm (
  input  logic clk,
  input  logic rst,
  input  logic tclk_s,
  input  logic uflow,
  output logic set
);
  logic prev_q;
  logic armed_q;
  logic fall;

  assign fall = prev_q & ~tclk_s;
  assign set  = fall & (armed_q | uflow);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      prev_q  <= tclk_s;
      armed_q <= fall ? 1'b0 : (armed_q | uflow);
    end
  end
endmodule

// File: rtl/irq_eoi_dec.sv
module irq_eoi_dec import irq_status_pkg::*; #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] A_STATUS = 8'h10,
  parameter logic [ADDR_W-1:0] A_TC1    = 8'h20,
  parameter logic [ADDR_W-1:0] A_TC2    = 8'h24,
  parameter logic [ADDR_W-1:0] A_RTC    = 8'h28,
  parameter logic [ADDR_W-1:0] A_TICK   = 8'h2C,
  parameter logic [ADDR_W-1:0] A_MDM    = 8'h30,
  parameter logic [ADDR_W-1:0] A_SSI    = 8'h38
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  output src_vec_t          clr,
  output logic              stat_rd
);
  always_comb begin
    clr         = '0;
    clr[B_TMR1] = wr && (addr == A_TC1);
    clr[B_TMR2] = wr && (addr == A_TC2);
    clr[B_RTC]  = wr && (addr == A_RTC);
    clr[B_TICK] = wr && (addr == A_TICK);
    clr[B_MDM]  = wr && (addr == A_MDM);
    clr[B_SEOT] = rd && (addr == A_SSI);
    stat_rd     = rd && (addr == A_STATUS);
  end
endmodule

// File: rtl/irq_status_agg.sv
module irq_status_agg import irq_status_pkg::*; #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] A_STATUS = 8'h10,
  parameter logic [ADDR_W-1:0] A_TC1    = 8'h20,
  parameter logic [ADDR_W-1:0] A_TC2    = 8'h24,
  parameter logic [ADDR_W-1:0] A_RTC    = 8'h28,
  parameter logic [ADDR_W-1:0] A_TICK   = 8'h2C,
  parameter logic [ADDR_W-1:0] A_MDM    = 8'h30,
  parameter logic [ADDR_W-1:0] A_SSI    = 8'h38,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              fiq_n,
  input  logic              bat_low,
  input  logic              wdog_exp,
  input  logic              media_chg,
  input  logic              codec_irq,
  input  logic              ext1_n,
  input  logic              ext2_n,
  input  logic              ext3,
  input  logic [1:0]        tmr_clk,
  input  logic [1:0]        tmr_uflow,
  input  logic              rtc_match,
  input  logic              tick_evt,
  input  logic              modem_evt,
  input  logic              ssi_done,
  input  logic              uart_tx_lvl,
  input  logic              uart_rx_lvl,
  output logic [15:0]       irq_status,
  output logic [31:0]       rd_data,
  output logic              rd_valid
);
  localparam int SYNC_W = NPIN + NTMR;
  localparam logic [SYNC_W-1:0] SYNC_RST = {{NTMR{1'b0}}, PIN_ACT_LOW};

  logic [SYNC_W-1:0] raw_in, sync_out;
  logic [NPIN-1:0]   pin_act;
  logic [NTMR-1:0]   tmr_set;
  src_vec_t          lvl_v, set_v, clr_v, status_q, status_d;
  logic              stat_rd;

  assign raw_in = {tmr_clk, ext3, ext2_n, ext1_n, codec_irq,
                   media_chg, wdog_exp, bat_low, fiq_n};

  irq_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst(rst), .d(raw_in), .q(sync_out)
  );

  assign pin_act = sync_out[NPIN-1:0] ^ PIN_ACT_LOW;

  for (genvar t = 0; t < NTMR; t++) begin : g_tmr
    irq_tmr_arm u_arm (
      .clk(clk), .rst(rst), .tclk_s(sync_out[NPIN+t]),
      .uflow(tmr_uflow[t]), .set(tmr_set[t])
    );
  end

  irq_eoi_dec #(
    .ADDR_W(ADDR_W), .A_STATUS(A_STATUS), .A_TC1(A_TC1), .A_TC2(A_TC2),
    .A_RTC(A_RTC), .A_TICK(A_TICK), .A_MDM(A_MDM), .A_SSI(A_SSI)
  ) u_dec (
    .addr(bus_addr), .wr(bus_wr), .rd(bus_rd), .clr(clr_v), .stat_rd(stat_rd)
  );

  always_comb begin
    lvl_v                 = '0;
    lvl_v[B_FIQ+NPIN-1:B_FIQ] = pin_act;
    lvl_v[B_UTX]          = uart_tx_lvl;
    lvl_v[B_URX]          = uart_rx_lvl;

    set_v                 = '0;
    set_v[B_TMR1]         = tmr_set[0];
    set_v[B_TMR2]         = tmr_set[1];
    set_v[B_RTC]          = rtc_match;
    set_v[B_TICK]         = tick_evt;
    set_v[B_MDM]          = modem_evt;
    set_v[B_SEOT]         = ssi_done;

    // set takes priority over a clear in the same cycle
    status_d = (LATCH_MASK & (set_v | (status_q & ~clr_v))) |
               (~LATCH_MASK & lvl_v);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      status_q <= status_d;
      rd_valid <= stat_rd;
      rd_data  <= stat_rd ? {{(DATA_W-NSRC){1'b0}}, status_q} : '0;
    end
  end

  assign irq_status = status_q;
endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] A_STATUS = 8'h10,
  parameter logic [ADDR_W-1:0] A_RTC    = 8'h28,
  parameter logic [ADDR_W-1:0] A_TICK   = 8'h2C,
  parameter logic [ADDR_W-1:0] A_SSI    = 8'h38
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic              rtc_match,
  input logic              tick_evt,
  input logic              ssi_done,
  input logic              uart_tx_lvl,
  input logic [15:0]       irq_status,
  input logic [31:0]       rd_data,
  input logic              rd_valid
);
  // R2
  rd_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> rd_data[31:16] == 16'h0);
  // R2
  rd_valid_timing_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == A_STATUS) |=> rd_valid);
  // R2
  rd_word_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == A_STATUS) |=> rd_data[15:0] == $past(irq_status));
  // R7
  rtc_set_chk: assert property (@(posedge clk) disable iff (rst)
    rtc_match |=> irq_status[10]);
  // R7
  rtc_eoi_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == A_RTC && !rtc_match) |=> !irq_status[10]);
  // R7
  tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_status[11] && !(bus_wr && bus_addr == A_TICK)) |=> irq_status[11]);
  // R8
  seot_rd_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == A_SSI && !ssi_done) |=> !irq_status[15]);
  // R10
  seot_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    ssi_done |=> irq_status[15]);
  // R9
  utx_follow_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> irq_status[12] == $past(uart_tx_lvl));
  // R7
  tick_set_chk: assert property (@(posedge clk) disable iff (rst)
    tick_evt |=> irq_status[11]);
endmodule

bind irq_status_agg irq_status_chk #(
  .ADDR_W(ADDR_W), .A_STATUS(A_STATUS), .A_RTC(A_RTC), .A_TICK(A_TICK), .A_SSI(A_SSI)
) u_chk (.*);

// File: tb/irq_status_agg_bench.sv
`timescale 1ns/1ps
module irq_status_agg_bench;
  localparam logic [7:0] A_STATUS = 8'h10, A_TC1 = 8'h20, A_TC2 = 8'h24,
                         A_RTC = 8'h28, A_TICK = 8'h2C, A_MDM = 8'h30, A_SSI = 8'h38;

  logic clk = 1'b0, rst = 1'b1;
  logic [7:0] bus_addr = '0;
  logic bus_wr = 0, bus_rd = 0;
  logic fiq_n = 1, bat_low = 0, wdog_exp = 0, media_chg = 0, codec_irq = 0;
  logic ext1_n = 1, ext2_n = 1, ext3 = 0;
  logic [1:0] tmr_clk = 2'b00, tmr_uflow = 2'b00;
  logic rtc_match = 0, tick_evt = 0, modem_evt = 0, ssi_done = 0;
  logic uart_tx_lvl = 0, uart_rx_lvl = 0;
  logic [15:0] irq_status;
  logic [31:0] rd_data;
  logic rd_valid;

  int n_tests = 0, n_fail = 0;
  logic [31:0] exp_q [$];
  string tag_q [$];

  always #10 clk = ~clk;

  irq_status_agg u_irq_status_agg (.*);

  task automatic tk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic [15:0] exp, input string tag);
    n_tests++;
    if (irq_status !== exp) begin
      n_fail++;
      $display("FAIL %s: irq_status=%h expected=%h", tag, irq_status, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a);
    @(negedge clk); bus_wr = 1; bus_addr = a;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic bus_read(input logic [7:0] a);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0;
  endtask

  // driver: pushes the expected word, then issues the read
  task automatic read_status(input logic [15:0] exp, input string tag);
    @(negedge clk); bus_rd = 1; bus_addr = A_STATUS;
    exp_q.push_back({16'h0, exp}); tag_q.push_back(tag);
    @(negedge clk); bus_rd = 0;
  endtask

  // monitor: pops and compares each returned word
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      n_tests++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R2: unexpected rd_valid rd_data=%h expected=none", rd_data);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        if (rd_data !== e) begin
          n_fail++;
          $display("FAIL %s: rd_data=%h expected=%h", t, rd_data, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    tk(3); rst = 0; tk(4);
    // R1 reset state
    chk(16'h0000, "R1 status after reset");
    n_tests++;
    if (rd_valid !== 1'b0 || rd_data !== 32'h0) begin
      n_fail++;
      $display("FAIL R1: rd_valid=%b rd_data=%h expected=0/0", rd_valid, rd_data);
    end
    read_status(16'h0000, "R2 read after reset");

    // R4 / R3 pins, exact latency
    @(negedge clk); fiq_n = 0; bat_low = 1;
    tk(2); chk(16'h0000, "R4 latency not yet");
    tk(1); chk(16'h0003, "R4 fiq low / R3 batlow high");
    read_status(16'h0003, "R2 read pins");
    @(negedge clk); fiq_n = 1; bat_low = 0; ext1_n = 0; ext2_n = 0; ext3 = 1;
    wdog_exp = 1; media_chg = 1; codec_irq = 1;
    tk(3); chk(16'h00FC, "R3 R4 external and misc pins");
    @(negedge clk); ext1_n = 1; ext2_n = 1; ext3 = 0;
    wdog_exp = 0; media_chg = 0; codec_irq = 0;
    tk(3); chk(16'h0000, "R4 pins return passive");

    // R9 serial levels
    @(negedge clk); uart_tx_lvl = 1;
    tk(1); chk(16'h1000, "R9 tx level");
    uart_rx_lvl = 1;
    tk(1); chk(16'h3000, "R9 rx level");
    uart_tx_lvl = 0; uart_rx_lvl = 0;
    tk(1); chk(16'h0000, "R9 levels drop");

    // R5 timers
    @(negedge clk); tmr_clk = 2'b11; tk(4);
    chk(16'h0000, "R5 rising timer clock sets nothing");
    tmr_uflow[0] = 1; tk(1); tmr_uflow[0] = 0; tk(3);
    chk(16'h0000, "R5 underflow waits for falling edge");
    tmr_clk[0] = 0;
    tk(2); chk(16'h0000, "R5 fall latency not yet");
    tk(1); chk(16'h0100, "R5 timer1 set after fall");
    tmr_clk[1] = 0; tk(4);
    chk(16'h0100, "R5 timer2 fall with no underflow");
    tmr_clk = 2'b11; tk(3);
    tmr_uflow[1] = 1; tk(1); tmr_uflow[1] = 0;
    tmr_clk[1] = 0; tk(3);
    chk(16'h0300, "R5 timer2 set after fall");

    // R6 timer EOI
    bus_write(A_TC1); chk(16'h0200, "R6 timer1 EOI clears bit 8 only");
    bus_write(A_TC2); chk(16'h0000, "R6 timer2 EOI clears bit 9");

    // R7 latched events
    @(negedge clk); rtc_match = 1; @(negedge clk); rtc_match = 0;
    chk(16'h0400, "R7 rtc latch");
    tick_evt = 1; @(negedge clk); tick_evt = 0;
    modem_evt = 1; @(negedge clk); modem_evt = 0;
    chk(16'h4C00, "R7 tick and modem latch");
    bus_write(A_TICK); chk(16'h4400, "R7 tick EOI clears only tick");
    bus_write(A_RTC);  chk(16'h4000, "R7 rtc EOI");
    bus_write(A_MDM);  chk(16'h0000, "R7 modem EOI");

    // R8 converter end-of-transfer
    @(negedge clk); ssi_done = 1; @(negedge clk); ssi_done = 0;
    chk(16'h8000, "R8 end-of-transfer latch");
    bus_write(A_SSI); chk(16'h8000, "R8 write to data address ignored");
    bus_read(A_SSI);  chk(16'h0000, "R8 data read clears");

    // R10 set beats clear
    @(negedge clk); rtc_match = 1; bus_wr = 1; bus_addr = A_RTC;
    @(negedge clk); rtc_match = 0; bus_wr = 0;
    chk(16'h0400, "R10 rtc set wins over EOI");
    @(negedge clk); ssi_done = 1; bus_rd = 1; bus_addr = A_SSI;
    @(negedge clk); ssi_done = 0; bus_rd = 0;
    chk(16'h8400, "R10 seot set wins over data read");
    bus_write(A_RTC); bus_read(A_SSI);
    chk(16'h0000, "R10 later clears work");

    // R11 writes to status address ignored
    @(negedge clk); tick_evt = 1; @(negedge clk); tick_evt = 0;
    bus_write(A_STATUS);
    chk(16'h0800, "R11 status write ignored");
    read_status(16'h0800, "R11 R2 readback after status write");
    bus_write(A_TICK); chk(16'h0000, "R7 tick cleared at end");

    tk(3);
    n_tests++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R2: pending reads=%0d expected=0", exp_q.size());
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule